// File: doc/BRIEF.md
# Pairwise 24-bit Module CRC Engine

This engine computes the 24-bit check value that closes an executable image. It does not advance one bit at a time. It takes the image two bytes per step. Each step folds the pair into a 24-bit accumulator using a masked term, two right-shifted copies of that term, and an extra constant that is applied when the term has odd parity. The last three byte positions of the image are kept for the result, so the engine folds only the whole pairs that fit before them.

A job begins with a start pulse together with the total image length in bytes. The data pairs then arrive on a valid/ready stream, one pair per beat, with the earlier byte in the upper half. After the last pair the accumulator is inverted. The resulting 24-bit value appears on `crc_out` and also leaves, one byte per beat, on a valid/ready output stream. These three bytes are the ones to place directly after the folded pairs. A `done` flag marks the end of the job.

Top module: `mcrc24_engine`

## Requirements
- R1: A start pulse accepted while idle loads the accumulator with 0xFFFFFF. This seed alone yields a check value of 0x000000.
- R2: For a pair with earlier byte `a` and later byte `b`, each step works as follows. Form W = a<<16 | b<<8. Take Z = (W xor acc) and 0x00FFFF00. The next accumulator is ((acc and 0xFF)<<16) xor (Z>>2) xor (Z>>7).
- R3: When Z has an odd number of set bits, the next accumulator is also xored with 0x800021. When the count is even, it is not.
- R4: A job folds exactly (length-3)/2 pairs, using integer division. `in_ready` is high only while pairs are still owed. Pairs offered after that are not consumed and do not change the result.
- R5: After the last pair, the accumulator is xored with 0xFFFFFF. The result is held on `crc_out` from the end of the job until the next one.
- R6: The check value leaves on `out_data` in three beats, most significant byte first. A byte is held stable while `out_valid` is high and `out_ready` is low.
- R7: `done` rises in the cycle after the third output byte is accepted. It stays high until the next start is accepted, and drops in the cycle after that start.
- R8: A start pulse arriving during a job is ignored. The job in progress completes with the length it was started with.
- R9: A length below 3 skips the fold loop entirely and emits 0x000000.
- R10: After reset, `in_ready`, `out_valid` and `done` are low.
- R11: While pairs are owed and `in_valid` stays high, one pair is taken every clock. `in_ready` and `out_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Starts a job when the engine is idle |
| total_len | input | LEN_W | Image length in bytes, sampled with start |
| in_pair | input | 16 | Data pair: earlier byte in [15:8], later byte in [7:0] |
| in_valid | input | 1 | `in_pair` holds a pair |
| in_ready | output | 1 | Engine takes a pair on this clock |
| out_data | output | 8 | Check value byte, most significant first |
| out_valid | output | 1 | `out_data` holds a byte |
| out_ready | input | 1 | Sink takes the byte on this clock |
| crc_out | output | 24 | Finished check value |
| done | output | 1 | Job complete |

## Verification
A wrong fold or a missing parity term leaves a mark in every later accumulator value. Such an error therefore shows up at the ports within the same job, in both `crc_out` and the three emitted bytes. A miscounted pair number shows up a different way. `in_ready` stays high for one beat too many or too few, which changes the result and makes the handshake count differ from (length-3)/2. A bad byte index or a bad `done` timing is visible within four cycles of the last pair: as bytes out of order, or as `done` appearing on the wrong side of the final accept.

// File: rtl/mcrc24_pkg.sv
package mcrc24_pkg;
  localparam int ACC_W = 24;
  localparam int RESV_BYTES = 3;
  localparam logic [ACC_W-1:0] SEED_VAL = 24'hFFFFFF;
  localparam logic [ACC_W-1:0] FINAL_XOR = 24'hFFFFFF;
  localparam logic [ACC_W-1:0] FOLD_MASK = 24'hFFFF00;
  localparam logic [ACC_W-1:0] PARITY_POLY = 24'h800021;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FOLD = 2'd1,
    ST_FIN  = 2'd2,
    ST_EMIT = 2'd3
  } eng_state_t;
endpackage

// File: rtl/mcrc24_step.sv
module mcrc24_step
  import mcrc24_pkg::*;
(
  input  logic [ACC_W-1:0] acc_i,
  input  logic [7:0]       b_hi,
  input  logic [7:0]       b_lo,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] w, z, base, odd_term;

  always_comb begin
    w        = {b_hi, b_lo, 8'h00};
    z        = (w ^ acc_i) & FOLD_MASK;
    base     = {acc_i[7:0], 16'h0000};
    odd_term = (^z) ? PARITY_POLY : '0;
    acc_o    = base ^ (z >> 2) ^ (z >> 7) ^ odd_term;
  end
endmodule

// File: rtl/mcrc24_pair_count.sv
module mcrc24_pair_count
  import mcrc24_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] len_i,
  input  logic             dec,
  output logic             zero_on_load,
  output logic             last
);
  logic [LEN_W-1:0] pairs_calc, left_q;

  always_comb begin
    if (len_i < LEN_W'(RESV_BYTES)) pairs_calc = '0;
    else                            pairs_calc = (len_i - LEN_W'(RESV_BYTES)) >> 1;
    zero_on_load = (pairs_calc == '0);
    last         = (left_q == LEN_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst)       left_q <= '0;
    else if (load) left_q <= pairs_calc;
    else if (dec)  left_q <= left_q - LEN_W'(1);
  end

  // R4: a pair is never taken when none is owed
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    dec |-> (left_q != '0));
endmodule

// File: rtl/mcrc24_tx.sv
module mcrc24_tx #(
  parameter int NBYTES = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [8*NBYTES-1:0] word_i,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [7:0]          out_data,
  output logic                fin
);
  localparam int IW = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam int SW = 8 * NBYTES;

  logic [SW-1:0] sh_q;
  logic [IW-1:0] idx_q;
  logic          fire;

  assign out_data = sh_q[SW-1 -: 8];
  assign fire     = out_valid && out_ready;
  assign fin      = fire && (idx_q == IW'(NBYTES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q      <= '0;
      idx_q     <= '0;
      out_valid <= 1'b0;
    end else if (load) begin
      sh_q      <= word_i;
      idx_q     <= '0;
      out_valid <= 1'b1;
    end else if (fire) begin
      sh_q  <= sh_q << 8;
      idx_q <= idx_q + IW'(1);
      if (fin) out_valid <= 1'b0;
    end
  end

  // R6: a stalled byte stays put
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !load) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/mcrc24_engine.sv
module mcrc24_engine
  import mcrc24_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] total_len,
  input  logic [15:0]      in_pair,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [7:0]       out_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [23:0]      crc_out,
  output logic             done
);
  eng_state_t       state_q;
  logic [ACC_W-1:0] acc_q, acc_nx;
  logic             in_fire, take_start, zero_on_load, last_pair, tx_fin;

  assign in_ready   = (state_q == ST_FOLD);
  assign in_fire    = in_ready && in_valid;
  assign take_start = (state_q == ST_IDLE) && start;

  mcrc24_step u_step (
    .acc_i(acc_q), .b_hi(in_pair[15:8]), .b_lo(in_pair[7:0]), .acc_o(acc_nx)
  );

  mcrc24_pair_count #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst(rst), .load(take_start), .len_i(total_len),
    .dec(in_fire), .zero_on_load(zero_on_load), .last(last_pair)
  );

  mcrc24_tx #(.NBYTES(RESV_BYTES)) u_tx (
    .clk(clk), .rst(rst), .load(state_q == ST_FIN), .word_i(acc_q ^ FINAL_XOR),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data), .fin(tx_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      acc_q   <= SEED_VAL;
      crc_out <= '0;
      done    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          acc_q   <= SEED_VAL;
          done    <= 1'b0;
          state_q <= zero_on_load ? ST_FIN : ST_FOLD;
        end
        ST_FOLD: if (in_valid) begin
          acc_q <= acc_nx;
          if (last_pair) state_q <= ST_FIN;
        end
        ST_FIN: begin
          crc_out <= acc_q ^ FINAL_XOR;
          state_q <= ST_EMIT;
        end
        default: if (tx_fin) begin
          done    <= 1'b1;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  // R1: an accepted start seeds the accumulator
  p_seed_r1: assert property (@(posedge clk) disable iff (rst)
    take_start |=> (acc_q == SEED_VAL));
  // R2: no pair offered, no change to the accumulator
  p_acc_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> $stable(acc_q));
  // R7: done follows the final accepted byte
  p_done_r7: assert property (@(posedge clk) disable iff (rst)
    tx_fin |=> (done && !out_valid));
  // R8: a start during a job leaves the accumulator alone
  p_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE && start && !in_fire) |=> $stable(acc_q));
  // R11: input and output handshakes never overlap
  p_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));
endmodule

// File: tb/sim_mcrc24_engine.sv
module sim_mcrc24_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] total_len = '0;
  logic [15:0] in_pair = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  out_data;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [23:0] crc_out;
  logic        done;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  mcrc24_engine #(.LEN_W(16)) u0 (
    .clk(clk), .rst(rst), .start(start), .total_len(total_len),
    .in_pair(in_pair), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .crc_out(crc_out), .done(done)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] model(input logic [7:0] img[256], input int len);
    logic [23:0] a, w, z, n;
    int np;
    a  = 24'hFFFFFF;
    np = (len < 3) ? 0 : (len - 3) / 2;
    for (int i = 0; i < np; i++) begin
      w = {img[2*i], img[2*i+1], 8'h00};
      z = (w ^ a) & 24'hFFFF00;
      n = {a[7:0], 16'h0000} ^ (z >> 2) ^ (z >> 7);
      if ($countones(z) % 2 == 1) n = n ^ 24'h800021;
      a = n;
    end
    return a ^ 24'hFFFFFF;
  endfunction

  task automatic run_job(input int len, input bit poke, input bit full_rate, input bit zero_fill, input string tag);
    logic [7:0]  img[256];
    logic [23:0] exp, got;
    int np, taken, steps, k, guard;
    bit stray;
    for (int i = 0; i < 256; i++) img[i] = zero_fill ? 8'h00 : 8'($urandom);
    np  = (len < 3) ? 0 : (len - 3) / 2;
    exp = model(img, len);
    @(negedge clk);
    start = 1'b1; total_len = 16'(len);
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, {tag, " R7 done cleared by start"}, 32'(done), 32'd0);
    taken = 0; steps = 0; guard = 0;
    while (taken < np && guard < 20000) begin
      if (guard != 0) @(negedge clk);
      guard++; steps++;
      in_valid  = full_rate ? 1'b1 : (($urandom % 4) != 0);
      in_pair   = {img[2*taken], img[2*taken+1]};
      start     = poke && (taken == np / 2);
      total_len = poke ? 16'(($urandom % 50) + 3) : 16'(len);
      if (in_valid && in_ready) taken++;
    end
    if (full_rate)
      chk(steps == np, {tag, " R11 one pair per clock"}, 32'(steps), 32'(np));
    if (np != 0) @(negedge clk);
    start = 1'b0; in_valid = 1'b1; in_pair = 16'hA55A;
    stray = 1'b0;
    for (int i = 0; i < 2; i++) begin
      if (in_ready) stray = 1'b1;
      if (i == 0) @(negedge clk);
    end
    chk(!stray, {tag, " R4 in_ready low once pairs are taken"}, 32'(stray), 32'd0);
    in_valid = 1'b0;
    k = 0; got = '0; guard = 0;
    while (k < 3 && guard < 2000) begin
      @(negedge clk);
      guard++;
      out_ready = (($urandom % 3) != 0);
      if (out_valid && out_ready) begin
        got = {got[15:0], out_data};
        if (k == 2) chk(done == 1'b0, {tag, " R7 done low before final accept"}, 32'(done), 32'd0);
        k++;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    chk(got == exp, {tag, " R2 R3 R6 byte stream"}, 32'(got), 32'(exp));
    chk(crc_out == exp, {tag, " R5 crc_out"}, 32'(crc_out), 32'(exp));
    chk(done == 1'b1, {tag, " R7 done after last byte"}, 32'(done), 32'd1);
  endtask

  initial begin
    void'($urandom(32'h1A2B3C));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b0 && out_valid == 1'b0 && done == 1'b0, "R10 reset state",
        32'({in_ready, out_valid, done}), 32'd0);
    run_job(3, 1'b0, 1'b0, 1'b0, "R1 seed only");
    run_job(0, 1'b0, 1'b0, 1'b0, "R9 len0");
    run_job(2, 1'b0, 1'b0, 1'b0, "R9 len2");
    run_job(5, 1'b0, 1'b1, 1'b1, "R1 zero pair");
    run_job(4, 1'b0, 1'b0, 1'b0, "R4 len4 no pair");
    run_job(6, 1'b0, 1'b0, 1'b0, "R4 odd tail");
    run_job(40, 1'b0, 1'b1, 1'b0, "R11 full rate");
    run_job(41, 1'b1, 1'b0, 1'b0, "R8 start while busy");
    run_job(255, 1'b0, 1'b1, 1'b0, "R3 long");
    for (int j = 0; j < 25; j++)
      run_job(int'($urandom % 120), ($urandom % 4) == 0, ($urandom % 3) == 0, 1'b0, "R2 random");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule